// File: doc/BRIEF.md
# Tone Burst Generator with Clean Stop

The block plays a square-wave tone for a set length of time without any help from a processor, and it always finishes with the tone output low. Two counters run from tick enables that the block divides down from its system clock. The tone counter counts up and down on a fine tick. It drives the output high when it reaches the half-period value and low when it returns to zero. The duration counter counts on a coarse tick, which is a fixed multiple of the fine tick, so that long bursts need only a narrow counter.

When the duration counter reaches its terminal count, it does not cut the tone off. It raises an internal completion flag and stops itself. The tone counter then halts at the next return to zero, where the output is already going low, so the burst never ends with a short pulse. That halt event also sets the single `halted` flag, even though the duration counter has already stopped, so `halted` alone tells the user that a new burst may start. A start strobe is accepted only while `halted` is high and both programmed values are non-zero.

Top module: `tone_burst_gen`

## Requirements
- R1: After reset, `halted` is 1 and `tone_out` is 0.
- R2: A `start` sampled while `halted` is 1, with non-zero `half_period` and `duration`, clears `halted` at that same clock edge and captures both values.
- R3: With fine tick period F = FINE_DIV clocks, `tone_out` rises F*H clocks after the accepted start edge, where H is the captured half-period. It then toggles every F*H clocks, so the full period is 2*F*H clocks.
- R4: The duration counter completes after D coarse ticks, where D is the captured duration and one coarse tick is COARSE_RATIO fine ticks. Completion sets the internal completion flag and stops the duration counter, while the tone keeps running.
- R5: The burst halts on the first fall of the tone (the tone counter reaching zero) that comes strictly after completion. At that edge `tone_out` falls and `halted` rises together, after N = floor(D*COARSE_RATIO / (2*H)) + 1 full periods.
- R6: If completion and a tone fall occur on the same clock edge, that fall does not halt the burst, and the tone runs one more full period.
- R7: A `start` while `halted` is 0 is ignored, together with any new `half_period` and `duration` values, and the running burst keeps its timing.
- R8: A `start` with `half_period` = 0 or `duration` = 0 is ignored. `halted` stays 1 and `tone_out` stays 0.
- R9: Whenever `halted` is 1, `tone_out` is 0.
- R10: `halted` is set only by the halt event. It does not change when the duration expires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both tick enables are derived from it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that requests a burst |
| half_period | input | HALF_W | Tone half-period in fine ticks |
| duration | input | DUR_W | Burst length in coarse ticks |
| tone_out | output | 1 | Square-wave tone; low when idle |
| halted | output | 1 | 1 when idle and ready for a new start |

## Verification
The duration expiry and a tone fall can land on the same clock edge. This is the point where the stop decision is made. The bench provokes it with a half-period of 2 and a duration of 1 under its small divider settings, which places the expiry on the second fine tick of the fall. A scoreboard holds the predicted edge times. The bench passes only if the tone runs a second full period, with `tone_out` falling and `halted` rising together at the later edge and no change at the coincident one.

// File: rtl/tbg_pkg.sv
package tbg_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tbg_dir_e;

  function automatic int unsigned div_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tbg_prescaler.sv
module tbg_prescaler #(
  parameter int unsigned FINE_DIV     = 125,
  parameter int unsigned COARSE_RATIO = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic fine_tick,
  output logic coarse_tick
);
  import tbg_pkg::*;
  localparam int unsigned CW = div_width(COARSE_RATIO);
  localparam logic [CW-1:0] COARSE_LAST = CW'(COARSE_RATIO - 1);

  logic [CW-1:0] coarse_cnt;

  generate
    if (FINE_DIV > 1) begin : g_fine_div
      localparam int unsigned FW = div_width(FINE_DIV);
      localparam logic [FW-1:0] FINE_LAST = FW'(FINE_DIV - 1);
      logic [FW-1:0] fine_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fine_cnt <= '0;
        end else if (clear) begin
          fine_cnt <= '0;
        end else if (run) begin
          fine_cnt <= (fine_cnt == FINE_LAST) ? '0 : fine_cnt + 1'b1;
        end
      end
      assign fine_tick = run && (fine_cnt == FINE_LAST);
    end else begin : g_fine_pass
      assign fine_tick = run;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_cnt <= '0;
    end else if (clear) begin
      coarse_cnt <= '0;
    end else if (fine_tick) begin
      coarse_cnt <= (coarse_cnt == COARSE_LAST) ? '0 : coarse_cnt + 1'b1;
    end
  end

  assign coarse_tick = fine_tick && (coarse_cnt == COARSE_LAST);
endmodule

// File: rtl/tbg_tone_counter.sv
module tbg_tone_counter #(
  parameter int unsigned HW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [HW-1:0] half_q,
  input  logic          tick,
  input  logic          done,
  output logic          tone_out,
  output logic          tone_run,
  output logic [HW-1:0] cnt,
  output logic          peak_match,
  output logic          zero_match,
  output logic          halt_evt
);
  import tbg_pkg::*;

  tbg_dir_e dir;

  function automatic logic [HW-1:0] step(input logic [HW-1:0] c, input tbg_dir_e d);
    return (d == DIR_UP) ? c + 1'b1 : c - 1'b1;
  endfunction

  logic [HW-1:0] nxt;
  assign nxt        = step(cnt, dir);
  assign peak_match = tick && tone_run && (dir == DIR_UP) && (nxt == half_q);
  assign zero_match = tick && tone_run && (dir == DIR_DOWN) && (nxt == '0);
  assign halt_evt   = zero_match && done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir      <= DIR_UP;
      tone_out <= 1'b0;
      tone_run <= 1'b0;
    end else if (load) begin
      cnt      <= '0;
      dir      <= DIR_UP;
      tone_out <= 1'b0;
      tone_run <= 1'b1;
    end else if (tick && tone_run) begin
      cnt <= nxt;
      if (peak_match) begin
        tone_out <= 1'b1;
        dir      <= DIR_DOWN;
      end else if (zero_match) begin
        tone_out <= 1'b0;
        dir      <= DIR_UP;
        if (halt_evt) tone_run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tbg_duration_counter.sv
module tbg_duration_counter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] dur_q,
  input  logic          tick,
  input  logic          halt_req,
  output logic          done,
  output logic          dur_run,
  output logic          dur_halted,
  output logic [DW-1:0] cnt,
  output logic          expire
);
  assign expire = tick && dur_run && ((cnt + 1'b1) == dur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      done       <= 1'b1;
      dur_run    <= 1'b0;
      dur_halted <= 1'b1;
    end else if (load) begin
      cnt        <= '0;
      done       <= 1'b0;
      dur_run    <= 1'b1;
      dur_halted <= 1'b0;
    end else begin
      if (tick && dur_run) begin
        cnt <= cnt + 1'b1;
        if (expire) begin
          done    <= 1'b1;
          dur_run <= 1'b0;
        end
      end
      // halt is honoured even when the counter already stopped itself
      if (halt_req) dur_halted <= 1'b1;
    end
  end
endmodule

// File: rtl/tone_burst_gen.sv
module tone_burst_gen #(
  parameter int unsigned FINE_DIV     = 125,
  parameter int unsigned COARSE_RATIO = 20,
  parameter int unsigned HALF_W       = 16,
  parameter int unsigned DUR_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HALF_W-1:0] half_period,
  input  logic [DUR_W-1:0]  duration,
  output logic              tone_out,
  output logic              halted
);
  logic              start_ok;
  logic [HALF_W-1:0] half_q;
  logic [DUR_W-1:0]  dur_q;
  logic              fine_tick, coarse_tick;
  logic              done, halt_evt, peak_match, zero_match, expire;
  logic              tone_run, dur_run;
  logic [HALF_W-1:0] tone_cnt;
  logic [DUR_W-1:0]  dur_cnt;

  assign start_ok = start && halted && (half_period != '0) && (duration != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= '0;
      dur_q  <= '0;
    end else if (start_ok) begin
      half_q <= half_period;
      dur_q  <= duration;
    end
  end

  tbg_prescaler #(.FINE_DIV(FINE_DIV), .COARSE_RATIO(COARSE_RATIO)) u_presc (
    .clk(clk), .rst_n(rst_n), .clear(start_ok), .run(!halted),
    .fine_tick(fine_tick), .coarse_tick(coarse_tick)
  );

  tbg_tone_counter #(.HW(HALF_W)) u_tone (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .half_q(half_q),
    .tick(fine_tick), .done(done), .tone_out(tone_out), .tone_run(tone_run),
    .cnt(tone_cnt), .peak_match(peak_match), .zero_match(zero_match),
    .halt_evt(halt_evt)
  );

  tbg_duration_counter #(.DW(DUR_W)) u_dur (
    .clk(clk), .rst_n(rst_n), .load(start_ok), .dur_q(dur_q),
    .tick(coarse_tick), .halt_req(halt_evt), .done(done), .dur_run(dur_run),
    .dur_halted(halted), .cnt(dur_cnt), .expire(expire)
  );
endmodule

// File: rtl/tbg_checker.sv
module tbg_checker #(
  parameter int unsigned HW = 16,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [HW-1:0] half_period,
  input logic [DW-1:0] duration,
  input logic          tone_out,
  input logic          halted,
  input logic          done,
  input logic          tone_run,
  input logic          dur_run,
  input logic [HW-1:0] tone_cnt,
  input logic [HW-1:0] half_q,
  input logic [DW-1:0] dur_cnt,
  input logic          peak_match,
  input logic          zero_match,
  input logic          expire
);
  a_r9_low_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !tone_out);

  a_r5_halt_with_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $fell(tone_out));

  a_r10_halt_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> done);

  a_r5_counters_agree: assert property (@(posedge clk) disable iff (!rst_n)
    tone_run == !halted);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !halted |-> (tone_cnt <= half_q));

  a_r3_peak_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    peak_match |=> tone_out);

  a_r3_zero_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    zero_match |=> !tone_out);

  a_r4_expire_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (done && !dur_run));

  a_r4_duration_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !halted) |=> $stable(dur_cnt));

  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !halted) |=> $stable(half_q));

  a_r8_zero_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (start && halted && (half_period == '0 || duration == '0)) |=> halted);
endmodule

bind tone_burst_gen tbg_checker #(.HW(HALF_W), .DW(DUR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
  .duration(duration), .tone_out(tone_out), .halted(halted), .done(done),
  .tone_run(tone_run), .dur_run(dur_run), .tone_cnt(tone_cnt),
  .half_q(half_q), .dur_cnt(dur_cnt), .peak_match(peak_match),
  .zero_match(zero_match), .expire(expire)
);

// File: tb/tone_burst_gen_test.sv
module tone_burst_gen_test;
  localparam int FD = 2;
  localparam int CR = 4;
  localparam int HW = 8;
  localparam int DW = 8;

  typedef struct {
    int    cyc;
    bit    kind;   // 0 tone_out, 1 halted
    bit    val;
    string req;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HW-1:0] half_period = '0;
  logic [DW-1:0] duration = '0;
  logic tone_out, halted;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit prev_tone, prev_halt;
  bit finished = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_burst_gen #(.FINE_DIV(FD), .COARSE_RATIO(CR), .HALF_W(HW), .DUR_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_period(half_period),
    .duration(duration), .tone_out(tone_out), .halted(halted)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic see_change(input bit kind, input bit val);
    item_t it;
    if (exp_q.size() == 0) begin
      check(1'b0, "R10", kind ? "unexpected halted change" : "unexpected tone change",
            cyc, -1);
    end else begin
      it = exp_q.pop_front();
      check(it.kind == kind && it.val == val && it.cyc == cyc, it.req,
            kind ? "halted edge cycle" : "tone edge cycle", cyc, it.cyc);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      if (tone_out !== prev_tone) see_change(1'b0, tone_out);
      if (halted !== prev_halt) see_change(1'b1, halted);
      prev_tone = tone_out;
      prev_halt = halted;
    end
  end

  task automatic push(input int c, input bit k, input bit v, input string r);
    item_t it;
    it.cyc = c; it.kind = k; it.val = v; it.req = r;
    exp_q.push_back(it);
  endtask

  // Drives one burst; optionally fires an ignored start mid-burst (R7).
  task automatic run_burst(input int h, input int d, input string req, input bit poke);
    int s, n, stop_at;
    @(negedge clk);
    half_period = HW'(h);
    duration = DW'(d);
    start = 1'b1;
    s = cyc + 1;
    n = (d * CR) / (2 * h) + 1;
    push(s, 1'b1, 1'b0, "R2");
    for (int i = 0; i < n; i++) begin
      push(s + FD * (2 * h * i + h), 1'b0, 1'b1, "R3");
      push(s + FD * 2 * h * (i + 1), 1'b0, 1'b0, (i == n - 1) ? req : "R3");
    end
    push(s + FD * 2 * h * n, 1'b1, 1'b1, req);
    stop_at = s + FD * 2 * h * n;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      half_period = 8'd7;
      duration = 8'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (cyc < stop_at + 3) @(negedge clk);
    check(exp_q.size() == 0, req, "pending scoreboard items", exp_q.size(), 0);
    check(halted && !tone_out, "R9", "idle low after burst", {halted, tone_out}, 2);
  endtask

  task automatic zero_start(input int h, input int d);
    @(negedge clk);
    half_period = HW'(h);
    duration = DW'(d);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    check(halted == 1'b1, "R8", "halted after zero start", halted, 1);
    check(tone_out == 1'b0, "R8", "tone after zero start", tone_out, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired: actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(halted == 1'b1, "R1", "halted in reset", halted, 1);
    check(tone_out == 1'b0, "R1", "tone in reset", tone_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(halted == 1'b1, "R1", "halted after reset", halted, 1);
    check(tone_out == 1'b0, "R1", "tone after reset", tone_out, 0);
    prev_tone = tone_out;
    prev_halt = halted;
    mon_en = 1'b1;

    run_burst(3, 2, "R4", 1'b0);  // expiry mid-period, two periods
    run_burst(2, 1, "R6", 1'b0);  // expiry coincides with a tone fall
    run_burst(5, 1, "R5", 1'b0);  // expiry inside first period
    run_burst(1, 3, "R7", 1'b1);  // start during burst ignored
    zero_start(0, 5);
    zero_start(4, 0);
    run_burst(4, 3, "R5", 1'b0);  // ready again after rejected starts

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule